// File: doc/BRIEF.md
# Serial Port Interrupt Prioritizer

This block sits beside a serial communications interface. It collects that interface's receive events, transmit events and DMA request events into one interrupt request line and a vector byte. Each event sets its own sticky bit in a status word. Several events share one vector, so software polls this word and clears bits by writing ones to them.

The pending levels are ranked in a fixed order, highest first: receive DMA, transmit DMA, receive interrupt, transmit interrupt. The winning level becomes a two-bit code. That code is placed in the vector so that each level gets its own 2-byte slot inside an 8-byte pointer block. The block's base comes from a software-written register. When the CPU acknowledges, the current vector is captured and held for its fetch.

Top module: `sci_irq_prioritizer`

## Requirements
- R1: An event input high at a rising clock edge sets its status bit. The status bit positions are: [0] data ready, [1] overrun, [2] framing error, [3] parity error, [4] address match, [5] break, [6] transmit buffer empty, [7] transmit shift register empty, [8] receive DMA request, [9] transmit DMA request.
- R2: A status bit stays set until software writes a one to that bit position with `clr_we` high. Bits written with zero are not changed.
- R3: If an event and a clear reach the same status bit in the same cycle, the bit ends up set.
- R4: The level codes, in priority order from highest to lowest, are: receive DMA = 0, transmit DMA = 1, receive interrupt = 2, transmit interrupt = 3. When no level is pending the code is 0.
- R5: The receive interrupt level is the OR of the six receive status bits, each gated by its bit in `rx_en`.
- R6: The transmit interrupt level is the selected empty bit ANDed with `tx_ie`. When `tx_sel_buf` is 1 the selected bit is buffer empty; when it is 0 the selected bit is shift register empty.
- R7: A DMA level is pending only when its status bit and its DMA enable are both set. With the DMA enable clear, the receive DMA bit joins the receive interrupt level (gated by `rx_en[0]`), and the transmit DMA bit joins the transmit interrupt level (gated by `tx_ie`).
- R8: `irq` is high exactly when at least one level is pending.
- R9: `vector` equals {base register, code, 1'b0}. The base register is loaded from `base_data` at a clock edge where `base_we` is high.
- R10: At an edge with `ack` high, `vector_q` takes the value of `vector`. At any other edge it holds its value.
- R11: After reset the status word, the base register and `vector_q` are all zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_evt | input | 6 | Receive event pulses (status bits 5..0) |
| tx_evt | input | 2 | [0] buffer empty, [1] shift register empty |
| rx_dma_evt | input | 1 | Receive DMA request event |
| tx_dma_evt | input | 1 | Transmit DMA request event |
| clr_we | input | 1 | Write strobe for write-one-to-clear |
| clr_data | input | 10 | Bits to clear in the status word |
| rx_en | input | 6 | Per-source receive interrupt enables |
| tx_ie | input | 1 | Transmit interrupt enable |
| tx_sel_buf | input | 1 | 1: buffer empty raises transmit level, 0: shift empty |
| rx_dma_en | input | 1 | Receive DMA level enable |
| tx_dma_en | input | 1 | Transmit DMA level enable |
| base_we | input | 1 | Base register write strobe |
| base_data | input | 5 | Vector base, vector bits [7:3] |
| ack | input | 1 | CPU interrupt acknowledge |
| status | output | 10 | Sticky status word |
| irq | output | 1 | Interrupt request |
| vector | output | 8 | Live vector byte |
| vector_q | output | 8 | Vector captured on acknowledge |

## Verification
Directed patterns come first:
- A single framing event shows that the event lands in the right status bit.
- A same-cycle event and clear separates "event wins" from "clear wins".
- All sources pending at once, then removed one level at a time, walks the code through 0, 1, 2 and 3. This exposes any swapped ranks.
- A lone pending shift-empty bit under both settings of the select bit, and a lone receive DMA bit with its DMA enable on and off, show the transmit selection and the DMA fallback.

Random sparse events, clears and configuration changes then mix levels in arbitrary combinations. They are compared every cycle against a bench model of the status word, the vector and the acknowledge capture.

// File: rtl/sciq_pkg.sv
// Package: shared constants and the level code type of the serial
// interrupt prioritizer. Assumes the status layout given in the brief.
package sciq_pkg;
    localparam int RX_N    = 6;            // receive event sources
    localparam int ST_W    = RX_N + 4;     // status word width
    localparam int ST_TXBE = RX_N;         // transmit buffer empty
    localparam int ST_TXSE = RX_N + 1;     // transmit shift empty
    localparam int ST_RXD  = RX_N + 2;     // receive DMA request
    localparam int ST_TXD  = RX_N + 3;     // transmit DMA request
    localparam int N_LVL   = 4;
    localparam int CODE_W  = 2;

    typedef enum logic [CODE_W-1:0] {
        LVL_RXDMA = 2'd0,
        LVL_TXDMA = 2'd1,
        LVL_RXINT = 2'd2,
        LVL_TXINT = 2'd3
    } lvl_code_e;
endpackage

// File: rtl/sciq_status.sv
// Sticky status word. Each event sets its bit; software clears bits by
// writing ones. An event arriving in the same cycle as a clear wins.
// Assumes event inputs are single-cycle or level, both are accepted.
module sciq_status #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_we,
    input  logic [W-1:0] clr,
    output logic [W-1:0] st
);
    logic [W-1:0] clr_mask;

    // Purpose: the clear mask only applies while the write strobe is high.
    always_comb clr_mask = clr_we ? clr : '0;

    // Purpose: set on event, clear on write-one, event has precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= '0;
        else        st <= (st & ~clr_mask) | evt;
    end

    // R3: every event seen at an edge is set afterwards
    a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((st & $past(evt)) == $past(evt)));

    // R2: a set bit only drops if a one was written to it
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(st) & ~st & ~($past(clr) & {W{$past(clr_we)}})) == '0));
endmodule

// File: rtl/sciq_level.sv
// Level formation and fixed-priority encoding. Builds the four levels
// from the status word and the enables, then outputs the code of the
// highest pending one (index 0 is highest). Purely combinational; the
// clock is only used by the assertions.
module sciq_level
    import sciq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ST_W-1:0]   st,
    input  logic [RX_N-1:0]   rx_en,
    input  logic              tx_ie,
    input  logic              tx_sel_buf,
    input  logic              rx_dma_en,
    input  logic              tx_dma_en,
    output logic [N_LVL-1:0]  lvl,
    output logic [CODE_W-1:0] code,
    output logic              any
);
    logic rx_fallback, tx_fallback, tx_empty_sel;

    // Purpose: DMA bits fall back to interrupt levels when DMA is off.
    always_comb begin
        rx_fallback  = st[ST_RXD] & ~rx_dma_en & rx_en[0];
        tx_fallback  = st[ST_TXD] & ~tx_dma_en;
        tx_empty_sel = tx_sel_buf ? st[ST_TXBE] : st[ST_TXSE];
    end

    // Purpose: assemble the four levels in priority order.
    always_comb begin
        lvl[LVL_RXDMA] = st[ST_RXD] & rx_dma_en;
        lvl[LVL_TXDMA] = st[ST_TXD] & tx_dma_en;
        lvl[LVL_RXINT] = (|(st[RX_N-1:0] & rx_en)) | rx_fallback;
        lvl[LVL_TXINT] = tx_ie & (tx_empty_sel | tx_fallback);
    end

    // Purpose: lowest index wins; scan from lowest priority upward.
    always_comb begin
        code = '0;
        for (int i = N_LVL - 1; i >= 0; i--) begin
            if (lvl[i]) code = CODE_W'(i);
        end
        any = |lvl;
    end

    // R4: the highest-ranked level always wins
    a_r4_rxdma_top: assert property (@(posedge clk) disable iff (!rst_n)
        lvl[LVL_RXDMA] |-> (code == LVL_RXDMA));
    // R4: the chosen code names a pending level
    a_r4_code_pending: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> lvl[code]);
    // R8: nothing pending means code zero
    a_r8_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        !any |-> (code == '0));
endmodule

// File: rtl/sciq_vector.sv
// Vector formation. Holds the software base register, forms the live
// vector {base, code, 0}, and captures it on CPU acknowledge.
// Assumes VEC_W leaves at least one base bit above the code.
module sciq_vector #(
    parameter int VEC_W  = 8,
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [VEC_W-CODE_W-2:0] base_data,
    input  logic [CODE_W-1:0] code,
    input  logic              ack,
    output logic [VEC_W-1:0]  vector,
    output logic [VEC_W-1:0]  vector_q
);
    localparam int BASE_W = VEC_W - CODE_W - 1;
    logic [BASE_W-1:0] base_q;

    // Purpose: software-written base of the pointer block.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_we) base_q <= base_data;
    end

    // Purpose: live vector; bit 0 is always zero.
    always_comb vector = {base_q, code, 1'b0};

    // Purpose: capture the vector for the CPU fetch on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)   vector_q <= '0;
        else if (ack) vector_q <= vector;
    end

    // R10: without acknowledge the captured vector holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ack)) |-> $stable(vector_q));
    // R9: the slot offset is always even
    a_r9_even_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (vector[0] == 1'b0) && (vector_q[0] == 1'b0));
endmodule

// File: rtl/sci_irq_prioritizer.sv
// Top of the serial port interrupt prioritizer. Packs the event inputs
// into the status layout, then chains status, level and vector units.
// Assumes the enable and select inputs come from a control register
// held outside this block.
module sci_irq_prioritizer
    import sciq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RX_N-1:0]   rx_evt,
    input  logic [1:0]        tx_evt,
    input  logic              rx_dma_evt,
    input  logic              tx_dma_evt,
    input  logic              clr_we,
    input  logic [ST_W-1:0]   clr_data,
    input  logic [RX_N-1:0]   rx_en,
    input  logic              tx_ie,
    input  logic              tx_sel_buf,
    input  logic              rx_dma_en,
    input  logic              tx_dma_en,
    input  logic              base_we,
    input  logic [4:0]        base_data,
    input  logic              ack,
    output logic [ST_W-1:0]   status,
    output logic              irq,
    output logic [7:0]        vector,
    output logic [7:0]        vector_q
);
    localparam int VEC_W = 8;

    logic [ST_W-1:0]   evt_all;
    logic [N_LVL-1:0]  lvl;
    logic [CODE_W-1:0] code;
    logic              any;

    // Purpose: place each event at its status bit position.
    always_comb evt_all = {tx_dma_evt, rx_dma_evt, tx_evt[1], tx_evt[0], rx_evt};

    sciq_status #(.W(ST_W)) u_status (
        .clk(clk), .rst_n(rst_n), .evt(evt_all),
        .clr_we(clr_we), .clr(clr_data), .st(status)
    );

    sciq_level u_level (
        .clk(clk), .rst_n(rst_n), .st(status), .rx_en(rx_en),
        .tx_ie(tx_ie), .tx_sel_buf(tx_sel_buf),
        .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en),
        .lvl(lvl), .code(code), .any(any)
    );

    sciq_vector #(.VEC_W(VEC_W), .CODE_W(CODE_W)) u_vector (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_data(base_data),
        .code(code), .ack(ack), .vector(vector), .vector_q(vector_q)
    );

    // Purpose: a single request line for all levels.
    always_comb irq = any;

    // R8: a pending receive DMA bit with its enable set raises the request
    a_r8_dma_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_RXD] && rx_dma_en) |-> (irq && vector[2:1] == LVL_RXDMA));
    // R1: a receive event raises its status bit one edge later
    a_r1_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt != '0) |=> ((status[RX_N-1:0] & $past(rx_evt)) == $past(rx_evt)));
endmodule

// File: tb/sci_irq_prioritizer_test.sv
`timescale 1ns/1ps
module sci_irq_prioritizer_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic rst_n;
    logic [5:0] rx_evt;  logic [1:0] tx_evt;
    logic rx_dma_evt, tx_dma_evt, clr_we;
    logic [9:0] clr_data;  logic [5:0] rx_en;
    logic tx_ie, tx_sel_buf, rx_dma_en, tx_dma_en, base_we, ack;
    logic [4:0] base_data;
    logic [9:0] status;  logic irq;  logic [7:0] vector, vector_q;

    sci_irq_prioritizer uut (.*);

    int checks = 0, errors = 0;
    logic [9:0] m_st;  logic [4:0] m_base;  logic [7:0] m_vq;

    // Expected levels per requirements R5, R6, R7 (bit 0 = highest).
    function automatic logic [3:0] f_lvl(logic [9:0] s);
        logic [3:0] l;
        l[0] = s[8] & rx_dma_en;
        l[1] = s[9] & tx_dma_en;
        l[2] = (|(s[5:0] & rx_en)) | (s[8] & ~rx_dma_en & rx_en[0]);
        l[3] = tx_ie & ((tx_sel_buf ? s[6] : s[7]) | (s[9] & ~tx_dma_en));
        return l;
    endfunction

    function automatic logic [1:0] f_code(logic [3:0] l);
        if (l[0]) return 2'd0;
        if (l[1]) return 2'd1;
        if (l[2]) return 2'd2;
        if (l[3]) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [7:0] f_vec(logic [9:0] s, logic [4:0] b);
        return {b, f_code(f_lvl(s)), 1'b0};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rx_evt = '0; tx_evt = '0; rx_dma_evt = 0; tx_dma_evt = 0;
        clr_we = 0; clr_data = '0; base_we = 0; base_data = '0; ack = 0;
    endtask

    // One clock: inputs are set at the negedge, model follows the edge.
    task automatic step();
        logic [9:0] nst;  logic [4:0] nb;  logic [7:0] nvq;
        nst = (m_st & ~(clr_we ? clr_data : 10'd0))
              | {tx_dma_evt, rx_dma_evt, tx_evt, rx_evt};
        nb  = base_we ? base_data : m_base;
        nvq = ack ? f_vec(m_st, m_base) : m_vq;
        @(posedge clk); #1;
        m_st = nst; m_base = nb; m_vq = nvq;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic clear_all();
        clr_we = 1; clr_data = '1; step();
    endtask

    initial begin : watchdog
        #(5ns * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; idle_inputs();
        rx_en = '1; tx_ie = 1; tx_sel_buf = 1; rx_dma_en = 1; tx_dma_en = 1;
        m_st = '0; m_base = '0; m_vq = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk("R11 status", status, 0); chk("R11 irq", irq, 0);
        chk("R11 vector_q", vector_q, 0); chk("R11 vector", vector, 0);
        rst_n = 1;
        @(negedge clk);

        // R1: framing event sets bit 2 only
        rx_evt = 6'b000100; step();
        chk("R1 framing bit", status, 10'h004);
        // R3: event and clear on the same bit keep it set
        rx_evt = 6'b000100; clr_we = 1; clr_data = 10'h004; step();
        chk("R3 event wins", status, 10'h004);
        // R2: clear with zero elsewhere only drops written bit
        rx_evt = 6'b000010; step();
        clr_we = 1; clr_data = 10'h004; step();
        chk("R2 w1c selective", status, 10'h002);
        clr_we = 0; clr_data = 10'h002; step();
        chk("R2 no strobe no clear", status, 10'h002);
        clear_all();

        // R4: all pending, peel off levels one by one
        rx_evt = 6'h3F; tx_evt = 2'b11; rx_dma_evt = 1; tx_dma_evt = 1; step();
        chk("R4 code rxdma", vector[2:1], 0);
        clr_we = 1; clr_data = 10'h100; step();
        chk("R4 code txdma", vector[2:1], 1);
        clr_we = 1; clr_data = 10'h200; step();
        chk("R4 code rxint", vector[2:1], 2);
        clr_we = 1; clr_data = 10'h03F; step();
        chk("R4 code txint", vector[2:1], 3);
        chk("R8 irq with tx", irq, 1);
        clear_all();
        chk("R8 irq idle", irq, 0);

        // R5: disabled receive source does not raise the level
        rx_en = 6'b111110; rx_evt = 6'b000001; step();
        chk("R5 masked source", irq, 0);
        rx_en = 6'b000001; @(negedge clk);
        chk("R5 enabled source", {irq, vector[2:1]}, 3'b110);
        rx_en = '1; clear_all();

        // R6: shift-empty pending only counts when selected
        tx_evt = 2'b10; tx_sel_buf = 1; step();
        chk("R6 buffer selected", irq, 0);
        tx_sel_buf = 0; @(negedge clk);
        chk("R6 shift selected", {irq, vector[2:1]}, 3'b111);
        tx_ie = 0; @(negedge clk);
        chk("R6 tx_ie gate", irq, 0);
        tx_ie = 1; tx_sel_buf = 1; clear_all();

        // R7: receive DMA falls back to receive interrupt
        rx_dma_evt = 1; rx_dma_en = 0; step();
        chk("R7 rx fallback", {irq, vector[2:1]}, 3'b110);
        rx_en = 6'b111110; @(negedge clk);
        chk("R7 fallback gated", irq, 0);
        rx_en = '1; rx_dma_en = 1; @(negedge clk);
        chk("R7 dma enabled", {irq, vector[2:1]}, 3'b100);
        clear_all();
        tx_dma_evt = 1; tx_dma_en = 0; step();
        chk("R7 tx fallback", {irq, vector[2:1]}, 3'b111);
        tx_dma_en = 1; clear_all();

        // R9 / R10: base register and acknowledge capture
        base_we = 1; base_data = 5'h15; rx_evt = 6'b010000; step();
        chk("R9 vector format", vector, {5'h15, 2'd2, 1'b0});
        ack = 1; step();
        chk("R10 capture", vector_q, {5'h15, 2'd2, 1'b0});
        clr_we = 1; clr_data = '1; step();
        chk("R10 hold", vector_q, {5'h15, 2'd2, 1'b0});

        // Random mix against the model
        for (int n = 0; n < 3000; n++) begin
            chk("R1 R2 status", status, m_st);
            chk("R8 irq", irq, |f_lvl(m_st));
            chk("R4 R9 vector", vector, f_vec(m_st, m_base));
            chk("R10 vector_q", vector_q, m_vq);
            for (int b = 0; b < 6; b++) rx_evt[b] = ($urandom % 10) == 0;
            tx_evt     = {($urandom % 8) == 0, ($urandom % 8) == 0};
            rx_dma_evt = ($urandom % 12) == 0;
            tx_dma_evt = ($urandom % 12) == 0;
            clr_we     = ($urandom % 3) == 0;
            clr_data   = 10'($urandom);
            base_we    = ($urandom % 20) == 0;
            base_data  = 5'($urandom);
            ack        = ($urandom % 4) == 0;
            if (($urandom % 16) == 0) begin
                rx_en = 6'($urandom); tx_ie = 1'($urandom);
                tx_sel_buf = 1'($urandom); rx_dma_en = 1'($urandom);
                tx_dma_en = 1'($urandom);
            end
            #0.5;
            chk("R8 irq cfg", irq, |f_lvl(m_st));
            step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule